// File: doc/BRIEF.md
# Energize-then-hold channel gate controller

This block decides, for one low-side switch, when the switch's gate is on. A load that must pull in hard, such as a solenoid or relay coil, is driven fully on for a programmable energize time after its channel is commanded on. After that the controller switches to a reduced-duty chopping waveform that holds the armature at a fraction of the power. The energize times form a fixed, nonlinear millisecond table selected by a 4-bit code. The hold duty is set in eighths by a 3-bit code. The chopping frequency is lowered for the two smallest duties.

An 8-bit control word sets the behaviour. Bit 7 is the timer enable, bits 6:4 are the hold duty code and bits 3:0 are the energize-time code. When the enable is 0, the channel stays fully on. If the energize timer is still running, a hold-start command pulse can move it into chopping early. A forced-off input from fault logic and the channel's data bit both remove the gate at once, in the same cycle, with no register in between. A millisecond tick drives the energize timer. The chopping counters are sized from the `CLK_HZ` parameter.

Top module: `hold_pwm_channel`

## Requirements
- R1: While reset is asserted, and after it is released, `gate_on` is 0 and the channel is idle until `data_bit` rises.
- R2: With ctrl bit 7 = 0 and energize code 0, a rise of `data_bit` turns the gate fully on from the next cycle for as long as `data_bit` stays 1. `hold_start` pulses are ignored.
- R3: The energize codes 0 to 15 select 0, 3, 5, 10, 15, 20, 30, 50, 80, 110, 140, 170, 200, 230, 260 and 300 `ms_tick` pulses. The energize phase starts in the cycle after the rise and ends on the tick that completes the count.
- R4: With ctrl bit 7 = 1 and energize code 0, a rise of `data_bit` enters chopping directly in the next cycle.
- R5: In chopping, the gate is on for the first n of 8 equal slots of each period, where n is the duty code in bits 6:4. Each period starts at slot 0 on entry. With n = 0 the gate is off once energizing ends.
- R6: A slot lasts CLK_HZ/400000 cycles for duty codes 3 to 7. It lasts twice that for code 2 and four times that for code 1, so the chopping rate is 50, 25 and 12.5 kHz respectively.
- R7: A `hold_start` pulse received while the energize timer is running moves the channel to chopping in the next cycle. This holds whatever the value of ctrl bit 7.
- R8: With ctrl bit 7 = 0 and a nonzero energize code, the gate stays fully on after the timer expires, and later `hold_start` pulses are ignored.
- R9: `data_bit` = 0 or `force_off` = 1 turns the gate off in the same cycle and returns the channel to idle. Only a new 0-to-1 edge of `data_bit` restarts the sequence, and the energize timer starts again from zero.
- R10: With ctrl bit 7 = 1 and a nonzero energize code, timer expiry moves the channel into chopping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| data_bit | input | 1 | Channel on command |
| ctrl | input | 8 | [7] timer enable, [6:4] duty code, [3:0] energize code |
| hold_start | input | 1 | One-cycle command that ends energizing early |
| force_off | input | 1 | Fault shutdown, removes the gate at once |
| gate_on | output | 1 | Gate drive for the low-side switch |

## Verification
The hardest case to reach is the race between a `hold_start` pulse and the end of the energize timer. Early entry to chopping is allowed only while the timer runs, and the pulse must be ignored once the timer has expired in the enable-0 mode. The bench generates the tick itself, so it controls exactly where each pulse lands. It places pulses a few ticks before expiry and again after it. It also walks all sixteen energize codes with a short tick spacing, so that the 300-tick case still completes within a short run. A forced-off pulse is applied in the middle of energizing while `data_bit` stays high. This shows that only a new edge restarts the timer.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ENRG = 2'd1,
    PH_FULL = 2'd2,
    PH_CHOP = 2'd3
  } phase_t;

  localparam int unsigned MS_W = 9;

  // energize length in millisecond ticks for each code
  function automatic logic [MS_W-1:0] energize_ms(input logic [3:0] code);
    logic [MS_W-1:0] ms;
    case (code)
      4'd0:  ms = 9'd0;
      4'd1:  ms = 9'd3;
      4'd2:  ms = 9'd5;
      4'd3:  ms = 9'd10;
      4'd4:  ms = 9'd15;
      4'd5:  ms = 9'd20;
      4'd6:  ms = 9'd30;
      4'd7:  ms = 9'd50;
      4'd8:  ms = 9'd80;
      4'd9:  ms = 9'd110;
      4'd10: ms = 9'd140;
      4'd11: ms = 9'd170;
      4'd12: ms = 9'd200;
      4'd13: ms = 9'd230;
      4'd14: ms = 9'd260;
      default: ms = 9'd300;
    endcase
    return ms;
  endfunction

endpackage

// File: rtl/hpc_energize_timer.sv
module hpc_energize_timer #(
  parameter int unsigned MS_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ms_tick,
  input  logic [MS_W-1:0] target,
  output logic            expired
);

  logic [MS_W-1:0] cnt_q;
  logic [MS_W-1:0] cnt_d;
  logic [MS_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{MS_W{1'b0}}, 1'b1};

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (ms_tick) begin
      cnt_d = cnt_inc[MS_W-1:0];
    end
  end

  assign expired = run & ms_tick & (cnt_inc >= {1'b0, target});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/hpc_chop_gen.sv
module hpc_chop_gen #(
  parameter int unsigned SLOT_CYC = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] duty,
  output logic       on
);

  localparam int unsigned PRE_W = $clog2(4 * SLOT_CYC + 1);

  logic [PRE_W-1:0] pre_q, pre_d, slot_last;
  logic [2:0]       slot_q, slot_d;

  // slower chopping for the two smallest duties
  always_comb begin
    case (duty)
      3'd1:    slot_last = PRE_W'(4 * SLOT_CYC - 1);
      3'd2:    slot_last = PRE_W'(2 * SLOT_CYC - 1);
      default: slot_last = PRE_W'(SLOT_CYC - 1);
    endcase
  end

  always_comb begin
    pre_d  = pre_q;
    slot_d = slot_q;
    if (!run) begin
      pre_d  = '0;
      slot_d = '0;
    end else if (pre_q >= slot_last) begin
      pre_d  = '0;
      slot_d = slot_q + 3'd1;
    end else begin
      pre_d  = pre_q + {{(PRE_W-1){1'b0}}, 1'b1};
    end
  end

  assign on = run & (slot_q < duty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      slot_q <= '0;
    end else begin
      pre_q  <= pre_d;
      slot_q <= slot_d;
    end
  end

endmodule

// File: rtl/hold_pwm_channel.sv
module hold_pwm_channel #(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       data_bit,
  input  logic [7:0] ctrl,
  input  logic       hold_start,
  input  logic       force_off,
  output logic       gate_on
);
  import hpc_pkg::*;

  localparam int unsigned BASE_HZ    = 50_000;
  localparam int unsigned PERIOD_CYC = CLK_HZ / BASE_HZ;
  localparam int unsigned SLOT_CYC   = PERIOD_CYC / 8;

  phase_t     phase_q, phase_d;
  logic       data_q;
  logic       rise;
  logic       tmr_en;
  logic [2:0] duty;
  logic [3:0] ecode;
  logic       expired;
  logic       chop_on;
  logic       gate_raw;

  assign tmr_en = ctrl[7];
  assign duty   = ctrl[6:4];
  assign ecode  = ctrl[3:0];
  assign rise   = data_bit & ~data_q;

  hpc_energize_timer #(.MS_W(MS_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (phase_q == PH_ENRG),
    .ms_tick (ms_tick),
    .target  (energize_ms(ecode)),
    .expired (expired)
  );

  hpc_chop_gen #(.SLOT_CYC(SLOT_CYC)) u_chop (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (phase_q == PH_CHOP),
    .duty  (duty),
    .on    (chop_on)
  );

  always_comb begin
    phase_d = phase_q;
    if (!data_bit || force_off) begin
      phase_d = PH_IDLE;
    end else if (rise) begin
      if (ecode == 4'd0) begin
        phase_d = tmr_en ? PH_CHOP : PH_FULL;
      end else begin
        phase_d = PH_ENRG;
      end
    end else if (phase_q == PH_ENRG) begin
      if (hold_start) begin
        phase_d = PH_CHOP;
      end else if (expired) begin
        phase_d = tmr_en ? PH_CHOP : PH_FULL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      data_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      data_q  <= data_bit;
    end
  end

  always_comb begin
    case (phase_q)
      PH_ENRG, PH_FULL: gate_raw = 1'b1;
      PH_CHOP:          gate_raw = chop_on;
      default:          gate_raw = 1'b0;
    endcase
  end

  assign gate_on = gate_raw & data_bit & ~force_off;

endmodule

// File: rtl/hpc_checker.sv
module hpc_checker (
  input logic           clk,
  input logic           rst_n,
  input logic           data_bit,
  input logic           force_off,
  input logic           hold_start,
  input logic [7:0]     ctrl,
  input logic           gate_on,
  input hpc_pkg::phase_t phase
);
  import hpc_pkg::*;

  // R9
  idle_after_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_bit || force_off) |=> (phase == PH_IDLE));

  // R7
  early_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ENRG && data_bit && !force_off && hold_start) |=> (phase == PH_CHOP));

  // R8
  stay_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FULL && data_bit && !force_off) |=> (phase == PH_FULL));

  // R5
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CHOP && ctrl[6:4] == 3'd0) |-> !gate_on);

  // R2
  full_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FULL && data_bit && !force_off) |-> gate_on);

  // R4
  direct_chop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_bit && !$past(data_bit) && !force_off && ctrl[7] && ctrl[3:0] == 4'd0)
      |=> (phase == PH_CHOP));

endmodule

bind hold_pwm_channel hpc_checker u_hpc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .data_bit   (data_bit),
  .force_off  (force_off),
  .hold_start (hold_start),
  .ctrl       (ctrl),
  .gate_on    (gate_on),
  .phase      (phase_q)
);

// File: tb/test_hold_pwm_channel.sv
`timescale 1ns/1ps
module test_hold_pwm_channel;

  localparam int unsigned CLK_HZ = 400_000;  // one cycle per slot
  localparam int TICK_GAP = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ms_tick;
  logic       data_bit;
  logic [7:0] ctrl;
  logic       hold_start;
  logic       force_off;
  logic       gate_on;

  int checks = 0;
  int errors = 0;
  int tcnt   = 0;
  bit done   = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  hold_pwm_channel #(.CLK_HZ(CLK_HZ)) i_hold_pwm_channel (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .data_bit(data_bit),
    .ctrl(ctrl), .hold_start(hold_start), .force_off(force_off), .gate_on(gate_on)
  );

  // reference model
  int tbl[16] = '{0, 3, 5, 10, 15, 20, 30, 50, 80, 110, 140, 170, 200, 230, 260, 300};
  int m_ph, m_msc, m_pos;
  bit m_dq;

  function automatic int slot_len(int n);
    if (n == 1) return 4;
    if (n == 2) return 2;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_msc = 0; m_pos = 0; m_dq = 0;
    end else begin
      int np, code, n;
      bit en;
      code = int'(ctrl[3:0]);
      n    = int'(ctrl[6:4]);
      en   = ctrl[7];
      np   = m_ph;
      if (!data_bit || force_off) np = 0;
      else if (data_bit && !m_dq) np = (code == 0) ? (en ? 3 : 2) : 1;
      else if (m_ph == 1) begin
        if (hold_start) np = 3;
        else if (ms_tick && (m_msc + 1 >= tbl[code])) np = en ? 3 : 2;
      end
      m_msc = (m_ph == 1) ? (ms_tick ? m_msc + 1 : m_msc) : 0;
      m_pos = (m_ph == 3) ? (m_pos + 1) % (8 * slot_len(n)) : 0;
      m_ph  = np;
      m_dq  = data_bit;
    end
  end

  function automatic bit model_gate();
    int n;
    bit g;
    n = int'(ctrl[6:4]);
    g = (m_ph == 1) || (m_ph == 2) || (m_ph == 3 && m_pos < n * slot_len(n));
    return g && data_bit && !force_off;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s gate_on=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) chk(cur_req, gate_on, model_gate());
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      hold_start = 1'b0;
      tcnt++;
      ms_tick = (tcnt % TICK_GAP == 0);
    end
  endtask

  task automatic restart(logic [7:0] c);
    data_bit = 1'b0;
    run(3);
    ctrl = c;
    run(1);
    data_bit = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ms_tick = 1'b0; data_bit = 1'b0; ctrl = 8'h00;
    hold_start = 1'b0; force_off = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", gate_on, 1'b0);
    #1 rst_n = 1'b1;
    run(5);
    chk("R1", gate_on, 1'b0);

    // R2: mode 0, code 0, start pulses ignored
    cur_req = "R2";
    restart(8'h50);
    run(10); hold_start = 1'b1; run(10); hold_start = 1'b1; run(20);
    chk("R2", gate_on, 1'b1);

    // R3 / R8: every energize code in mode 0, start pulse after expiry
    for (int c = 1; c < 16; c++) begin
      cur_req = "R3";
      restart(8'h30 | 8'(c));
      run(tbl[c] * TICK_GAP - 6);
      cur_req = "R8";
      run(20);
      hold_start = 1'b1;
      run(10);
      chk("R8", gate_on, 1'b1);
    end

    // R4 / R5 / R6: direct chopping, every duty
    for (int n = 0; n < 8; n++) begin
      cur_req = "R4";
      restart(8'h80 | 8'(n << 4));
      run(3);
      cur_req = (n == 1 || n == 2) ? "R6" : "R5";
      run(75);
    end

    // R10 / R5: energize then chop, and duty 0 off after energize
    cur_req = "R10";
    restart(8'hB2);
    run(5 * TICK_GAP + 60);
    cur_req = "R5";
    restart(8'h81);
    run(3 * TICK_GAP + 30);
    chk("R5", gate_on, 1'b0);

    // R7: early start in both modes, just before expiry
    cur_req = "R7";
    restart(8'h55);
    run(18 * TICK_GAP);
    hold_start = 1'b1;
    run(40);
    restart(8'hD5);
    run(7);
    hold_start = 1'b1;
    run(40);

    // R9: forced off mid-energize, no restart without a new edge
    cur_req = "R9";
    restart(8'h64);
    run(20);
    force_off = 1'b1;
    run(4);
    force_off = 1'b0;
    run(30);
    chk("R9", gate_on, 1'b0);
    restart(8'h64);
    run(15 * TICK_GAP + 20);
    data_bit = 1'b0;
    run(5);
    chk("R9", gate_on, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule